// File: doc/BRIEF.md
# Memory Access Alignment Fault Checker

This block decides, one request at a time, whether a data access must be aborted because its address is not aligned well enough. It sits in front of address translation. Each request carries a virtual address, an access mode (fetch, read or write) and an access class. An internal policy generator turns the class into a five-bit policy word. The word holds the required alignment as a low-bit mask, a flag that permits unaligned addresses, and a marker bit that shows the word was built on purpose. A dedicated class passes a caller-supplied policy word straight through instead. A global strict-alignment input overrides the per-access permission for unaligned addresses. Instruction fetches are never checked.

Requests enter through a valid/ready handshake and pass through a single register slot. A request that passes the check is forwarded downstream one cycle after it is accepted. A request that fails is dropped, not forwarded. In the cycle after it is accepted, the block raises a one-cycle fault pulse and registers the faulting address. A sticky fault bit records that any fault occurred and stays set until the clear input is raised.

Top module: `align_fault_check`

## Requirements
- R1: The policy word has the alignment mask in bits [2:0] (0 byte, 1 halfword, 3 word, 7 doubleword), the unaligned-permitted flag in bit 3 and the marker in bit 4. Class code 15 uses `req_policy` unchanged.
- R2: For a data access (mode not 0) with the marker set, an alignment fault occurs exactly when `req_addr[2:0] & mask` is nonzero and either `strict_align` is 1 or the unaligned-permitted flag is 0.
- R3: A data access whose policy word has a clear marker raises `fault_policy` and never `fault_align`. Class codes 10 to 14 produce an all-zero policy word. The two fault pulses are never high together.
- R4: A fetch (mode 0) never faults, whatever its address, class or `strict_align`, and it is always forwarded.
- R5: Class 0 (single load/store) uses the size mask and permits unaligned access. Class 1 (exclusive load) and class 2 (prefetch) use the size mask and do not permit it. `req_size` codes 0,1,2,3 give masks 0,1,3,7.
- R6: Class 3 (doubleword), class 4 (return-from-exception read), class 5 (multi-word micro-op) and class 6 (word swap) use mask 3, with unaligned access not permitted. Class 7 (byte swap) uses mask 0 with it not permitted. Class 8 (halfword table branch) uses mask 1 and class 9 (byte table branch) uses mask 0, both with it permitted.
- R7: `fault_align`/`fault_policy` go high for exactly one cycle, in the cycle after the accepting edge. `fault_addr` then holds that request's address until the next fault.
- R8: A faulting request is not forwarded. A passing request appears on `fwd_valid`/`fwd_addr`/`fwd_mode` in the cycle after acceptance.
- R9: While `fwd_valid` is high and `fwd_ready` is low, the forwarded request holds steady and `req_ready` is low.
- R10: `fault_sticky` sets with any fault pulse and holds until `sticky_clr`. A fault in the same cycle as a clear wins.
- R11: After reset, `req_ready` is 1 and `fwd_valid`, both fault pulses, `fault_sticky` and `fault_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_align | input | 1 | Global strict-alignment control |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | ADDR_W | Virtual address |
| req_mode | input | 2 | 0 fetch, 1 read, 2 write, 3 other data |
| req_class | input | 4 | Access class code |
| req_size | input | 2 | Size code for classes 0 to 2 |
| req_policy | input | 5 | Raw policy word used by class 15 |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Downstream ready |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_mode | output | 2 | Forwarded mode |
| fault_align | output | 1 | Alignment fault pulse |
| fault_policy | output | 1 | Missing-marker fault pulse |
| fault_addr | output | ADDR_W | Address of the latest fault |
| sticky_clr | input | 1 | Clear for the sticky bit |
| fault_sticky | output | 1 | Sticky fault status |

## Verification
A wrong policy entry or fault term shows up at the ports in the very next cycle: the fault pulse toggles where it should not, and `fwd_valid` flips with it. The sweep of every class, size, low address offset and strict setting therefore isolates a single bad mask bit to one class and offset. A corrupted slot or sticky register shows up within one cycle of the next stalled handshake or clear. A bad slot gives a lost or changed `fwd_addr` under backpressure. A bad sticky register leaves `fault_sticky` unchanged after a clear, or never set.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int POL_W  = 5;
  localparam int MASK_W = 3;

  typedef enum logic [3:0] {
    CLS_LDST  = 4'd0,
    CLS_EXCL  = 4'd1,
    CLS_PREF  = 4'd2,
    CLS_DUAL  = 4'd3,
    CLS_RFE   = 4'd4,
    CLS_MULTI = 4'd5,
    CLS_SWPW  = 4'd6,
    CLS_SWPB  = 4'd7,
    CLS_TBH   = 4'd8,
    CLS_TBB   = 4'd9,
    CLS_RAW   = 4'd15
  } acc_class_e;

  typedef enum logic [1:0] {
    MODE_FETCH = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_OTHER = 2'd3
  } acc_mode_e;

  // bit 4 marker, bit 3 unaligned permitted, bits 2:0 mask
  typedef struct packed {
    logic              marker;
    logic              ua_ok;
    logic [MASK_W-1:0] mask;
  } policy_t;

  function automatic logic [MASK_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  function automatic policy_t make_pol(input logic [MASK_W-1:0] m, input logic ua);
    policy_t p;
    p.marker = 1'b1;
    p.ua_ok  = ua;
    p.mask   = m;
    return p;
  endfunction

  function automatic logic misaligned(input logic [MASK_W-1:0] lo, input logic [MASK_W-1:0] m);
    return |(lo & m);
  endfunction
endpackage

// File: rtl/afc_policy_gen.sv
module afc_policy_gen
  import afc_pkg::*;
(
  input  logic [3:0]       cls,
  input  logic [1:0]       size,
  input  logic [POL_W-1:0] raw,
  output policy_t          pol
);
  always_comb begin
    case (cls)
      CLS_LDST:  pol = make_pol(size_mask(size), 1'b1);
      CLS_EXCL,
      CLS_PREF:  pol = make_pol(size_mask(size), 1'b0);
      CLS_DUAL,
      CLS_RFE,
      CLS_MULTI,
      CLS_SWPW:  pol = make_pol(3'd3, 1'b0);
      CLS_SWPB:  pol = make_pol(3'd0, 1'b0);
      CLS_TBH:   pol = make_pol(3'd1, 1'b1);
      CLS_TBB:   pol = make_pol(3'd0, 1'b1);
      CLS_RAW:   pol = policy_t'(raw);
      default:   pol = '0;
    endcase
  end
endmodule

// File: rtl/afc_fault_eval.sv
module afc_fault_eval
  import afc_pkg::*;
(
  input  logic [MASK_W-1:0] addr_lo,
  input  logic [1:0]        mode,
  input  policy_t           pol,
  input  logic              strict,
  output logic              align_hit,
  output logic              marker_bad
);
  logic is_data;
  logic strict_req;

  assign is_data    = (mode != MODE_FETCH);
  assign strict_req = strict | ~pol.ua_ok;
  assign align_hit  = is_data & pol.marker & strict_req & misaligned(addr_lo, pol.mask);
  assign marker_bad = is_data & ~pol.marker;
endmodule

// File: rtl/align_fault_check.sv
module align_fault_check
  import afc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strict_align,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_mode,
  input  logic [3:0]          req_class,
  input  logic [1:0]          req_size,
  input  logic [POL_W-1:0]    req_policy,
  output logic                fwd_valid,
  input  logic                fwd_ready,
  output logic [ADDR_W-1:0]   fwd_addr,
  output logic [1:0]          fwd_mode,
  output logic                fault_align,
  output logic                fault_policy,
  output logic [ADDR_W-1:0]   fault_addr,
  input  logic                sticky_clr,
  output logic                fault_sticky
);
  policy_t pol;
  logic    align_hit;
  logic    marker_bad;
  logic    fault_now;
  logic    acc_fire;

  logic              slot_q;
  logic [ADDR_W-1:0] slot_addr_q;
  logic [1:0]        slot_mode_q;
  logic              fa_q, fp_q, sticky_q;
  logic [ADDR_W-1:0] fault_addr_q;

  afc_policy_gen u_pol (
    .cls  (req_class),
    .size (req_size),
    .raw  (req_policy),
    .pol  (pol)
  );

  afc_fault_eval u_eval (
    .addr_lo    (req_addr[MASK_W-1:0]),
    .mode       (req_mode),
    .pol        (pol),
    .strict     (strict_align),
    .align_hit  (align_hit),
    .marker_bad (marker_bad)
  );

  assign fault_now = align_hit | marker_bad;
  assign req_ready = ~slot_q | fwd_ready;
  assign acc_fire  = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q       <= 1'b0;
      slot_addr_q  <= '0;
      slot_mode_q  <= '0;
      fa_q         <= 1'b0;
      fp_q         <= 1'b0;
      sticky_q     <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      if (acc_fire && !fault_now) begin
        slot_q      <= 1'b1;
        slot_addr_q <= req_addr;
        slot_mode_q <= req_mode;
      end else if (fwd_ready) begin
        slot_q <= 1'b0;
      end
      fa_q <= acc_fire & align_hit;
      fp_q <= acc_fire & marker_bad;
      if (acc_fire && fault_now) begin
        fault_addr_q <= req_addr;
        sticky_q     <= 1'b1;
      end else if (sticky_clr) begin
        sticky_q <= 1'b0;
      end
    end
  end

  assign fwd_valid    = slot_q;
  assign fwd_addr     = slot_addr_q;
  assign fwd_mode     = slot_mode_q;
  assign fault_align  = fa_q;
  assign fault_policy = fp_q;
  assign fault_addr   = fault_addr_q;
  assign fault_sticky = sticky_q;
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_fire,
  input logic [1:0]        req_mode,
  input logic [ADDR_W-1:0] req_addr,
  input logic              align_hit,
  input logic              marker_bad,
  input logic              req_ready,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              fault_align,
  input logic              fault_policy,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              sticky_clr,
  input logic              fault_sticky
);
  a_r4_fetch_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_mode == 2'd0) |=> (!fault_align && !fault_policy && fwd_valid));

  a_r7_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && (align_hit || marker_bad)) |=> (fault_addr == $past(req_addr)));

  a_r7_pulse_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> (!fault_align && !fault_policy));

  a_r8_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_align || fault_policy) |-> !fwd_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr)));

  a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |-> !req_ready);

  a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_align, fault_policy}));

  a_r10_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_align || fault_policy) |-> fault_sticky);

  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sticky && !sticky_clr) |=> fault_sticky);
endmodule

bind align_fault_check afc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_fire     (acc_fire),
  .req_mode     (req_mode),
  .req_addr     (req_addr),
  .align_hit    (align_hit),
  .marker_bad   (marker_bad),
  .req_ready    (req_ready),
  .fwd_valid    (fwd_valid),
  .fwd_ready    (fwd_ready),
  .fwd_addr     (fwd_addr),
  .fault_align  (fault_align),
  .fault_policy (fault_policy),
  .fault_addr   (fault_addr),
  .sticky_clr   (sticky_clr),
  .fault_sticky (fault_sticky)
);

// File: tb/align_fault_check_bench.sv
module align_fault_check_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strict_align = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_mode = 2'd1;
  logic [3:0]    req_class = '0;
  logic [1:0]    req_size = '0;
  logic [4:0]    req_policy = '0;
  logic          fwd_valid;
  logic          fwd_ready = 1'b1;
  logic [AW-1:0] fwd_addr;
  logic [1:0]    fwd_mode;
  logic          fault_align, fault_policy, fault_sticky;
  logic [AW-1:0] fault_addr;
  logic          sticky_clr = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  align_fault_check #(.ADDR_W(AW)) u_align_fault_check (
    .clk(clk), .rst_n(rst_n), .strict_align(strict_align),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_mode(req_mode), .req_class(req_class), .req_size(req_size),
    .req_policy(req_policy), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .fwd_mode(fwd_mode), .fault_align(fault_align),
    .fault_policy(fault_policy), .fault_addr(fault_addr),
    .sticky_clr(sticky_clr), .fault_sticky(fault_sticky)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // alignment in bytes and unaligned permission, per class (R5, R6)
  function automatic int bytes_for(input int cls, input int sz);
    case (cls)
      0, 1, 2:       return 1 << sz;
      3, 4, 5, 6:    return 4;
      8:             return 2;
      default:       return 1;
    endcase
  endfunction

  function automatic bit ua_for(input int cls);
    return (cls == 0) || (cls == 8) || (cls == 9);
  endfunction

  // returns {fault_policy, fault_align}
  function automatic logic [1:0] expect_fault(input int cls, input int sz, input logic [4:0] raw,
                                              input logic [1:0] mode, input logic [AW-1:0] a, input bit strict);
    int  n;
    bit  ua, mk;
    if (mode == 2'd0) return 2'b00;
    if (cls == 15) begin
      mk = raw[4]; ua = raw[3]; n = int'(raw[2:0]) + 1;
    end else if (cls >= 10) begin
      mk = 1'b0; ua = 1'b0; n = 1;
    end else begin
      mk = 1'b1; ua = ua_for(cls); n = bytes_for(cls, sz);
    end
    if (!mk) return 2'b10;
    return {1'b0, ((int'(a[2:0]) % n) != 0) && (strict || !ua)};
  endfunction

  task automatic send(input int cls, input int sz, input logic [4:0] raw,
                      input logic [1:0] mode, input logic [AW-1:0] a, input bit strict);
    @(negedge clk);
    req_valid = 1'b1; req_class = 4'(cls); req_size = 2'(sz); req_policy = raw;
    req_mode = mode; req_addr = a; strict_align = strict;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic run_one(input int cls, input int sz, input logic [4:0] raw,
                         input logic [1:0] mode, input logic [AW-1:0] a, input bit strict, input string req);
    logic [1:0] e;
    e = expect_fault(cls, sz, raw, mode, a, strict);
    send(cls, sz, raw, mode, a, strict);
    check({fault_policy, fault_align} == e, req, {fault_policy, fault_align}, e);
    if (e == 2'b00)
      check(fwd_valid && fwd_addr == a && fwd_mode == mode, "R8 forward", fwd_addr, a);
    else
      check(!fwd_valid && fault_addr == a, "R8 R7 drop and capture", fault_addr, a);
  endtask

  function automatic logic [4:0] rand_raw();
    logic [2:0] m;
    case ($urandom % 4)
      0: m = 3'd0;
      1: m = 3'd1;
      2: m = 3'd3;
      default: m = 3'd7;
    endcase
    return {1'($urandom), 1'($urandom), m};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired R11 actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check(req_ready && !fwd_valid && !fault_align && !fault_policy && !fault_sticky && fault_addr == '0,
          "R11 reset", {fwd_valid, fault_align, fault_policy, fault_sticky}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R5 R6 sweep of classes, sizes, offsets, strict
    for (int c = 0; c < 10; c++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 8; o++)
          for (int st = 0; st < 2; st++)
            run_one(c, s, 5'd0, ((o + st) % 2 == 0) ? 2'd1 : 2'd2,
                    {$urandom, 3'(o)} , st[0], "R2 R5 R6 fault equation");

    // R4 fetch is never checked
    for (int c = 0; c < 16; c++)
      for (int o = 1; o < 8; o += 2)
        run_one(c, 3, 5'd0, 2'd0, {$urandom, 3'(o)}, 1'b1, "R4 fetch unchecked");

    // R3 missing marker: unused class codes and raw words without bit 4
    for (int c = 10; c < 15; c++)
      run_one(c, 0, 5'd0, 2'd1, 32'h100, 1'b0, "R3 unused class");
    run_one(15, 0, 5'b01000, 2'd2, 32'h203, 1'b1, "R3 raw no marker");
    run_one(15, 0, 5'b00000, 2'd3, 32'h200, 1'b0, "R3 raw all zero");

    // R1 raw policy words
    for (int i = 0; i < 120; i++)
      run_one(15, 0, {1'b1, rand_raw() & 5'h0f}, 2'(1 + $urandom % 3), $urandom, 1'($urandom), "R1 raw policy");

    // R7 pulse lasts one cycle, address held
    run_one(6, 0, 5'd0, 2'd1, 32'hABCD_0002, 1'b0, "R7 setup fault");
    idle();
    check(!fault_align && !fault_policy, "R7 pulse width", {fault_policy, fault_align}, 0);
    check(fault_addr == 32'hABCD_0002, "R7 address held", fault_addr, 32'hABCD_0002);

    // R10 sticky
    check(fault_sticky, "R10 sticky set", fault_sticky, 1);
    idle();
    check(fault_sticky, "R10 sticky held", fault_sticky, 1);
    @(negedge clk); sticky_clr = 1'b1; @(posedge clk); #1;
    check(!fault_sticky, "R10 sticky cleared", fault_sticky, 0);
    @(negedge clk);
    sticky_clr = 1'b1; req_valid = 1'b1; req_class = 4'd3; req_mode = 2'd1; req_addr = 32'h11; strict_align = 1'b0;
    @(posedge clk); #1;
    check(fault_sticky && fault_align, "R10 fault wins over clear", {fault_sticky, fault_align}, 3);
    @(negedge clk); sticky_clr = 1'b0; req_valid = 1'b0;

    // R9 backpressure
    fwd_ready = 1'b0;
    send(0, 2, 5'd0, 2'd2, 32'h4000, 1'b0);
    check(fwd_valid && fwd_addr == 32'h4000, "R9 loaded", fwd_addr, 32'h4000);
    check(!req_ready, "R9 ready low", req_ready, 0);
    send(0, 2, 5'd0, 2'd1, 32'h5000, 1'b0);
    check(fwd_valid && fwd_addr == 32'h4000, "R9 held", fwd_addr, 32'h4000);
    @(negedge clk); fwd_ready = 1'b1; @(posedge clk); #1;
    check(fwd_valid && fwd_addr == 32'h5000 && fwd_mode == 2'd1, "R9 drain then accept", fwd_addr, 32'h5000);
    idle();
    check(!fwd_valid, "R8 slot empties", fwd_valid, 0);

    // random mix R2
    for (int i = 0; i < 400; i++) begin
      int c;
      c = (i % 7 == 0) ? 15 : int'($urandom % 15);
      run_one(c, int'($urandom % 4), rand_raw(), 2'($urandom), $urandom, 1'($urandom), "R2 random");
    end

    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule